// File: doc/BRIEF.md
# Grayscale PWM Cycle Sequencer

This block produces the timing for a chain of constant-current PWM LED drivers. It derives a square-wave grayscale clock from the system clock and counts a fixed number of grayscale periods per PWM cycle. At the end of each cycle it stops that clock in the low state and then raises a blanking output for a fixed number of system clocks. Inside the blank it issues a one-clock latch pulse, but only if the companion serializer has reported a completed frame since the previous blank.

A clear-to-send flag tells the serializer when it may shift out a new frame. In the default mode the flag rises with each blank and falls once two thirds of the grayscale periods of the next cycle have passed, so that any transfer started in the window ends before the next blank. A completed frame also drops the flag. A parameter selects a second mode. In that mode the flag is raised only while blanked, the blank lasts until the frame arrives, and the latch and the restart of the cycle follow it.

A low global enable darkens all outputs at the next clock and keeps them dark. When enable returns, one full blanking interval runs before the outputs come back. After reset, the outputs are dark and no latch pulse is pending.

Top module: `gs_cycle_seq`

## Requirements
- R1: While running, the grayscale clock has a period of 2*HALF_DIV system clocks with a 50% duty cycle, starting low. A PWM cycle holds exactly 2**GS_BITS rising edges (4096 by default) between the fall of blank and its next rise.
- R2: At the end of a cycle, the grayscale clock is low for at least one system clock before blank rises. In the default mode, blank then stays high for exactly BLANK_CLKS system clocks, and the grayscale clock stays low for the whole time blank is high.
- R3: A blank contains one latch pulse, one system clock wide, if frame_done was strobed since the previous blank, and no pulse otherwise. The pulse falls in the second clock of the blank and is followed by at least one more blanked clock.
- R4: One clock after enable is sampled low, blank is high, the grayscale clock is low, clear_to_send is low and there is no latch pulse. This holds for as long as enable stays low.
- R5: When enable rises, blank stays high for a full blanking interval (BLANK_CLKS clocks in the default mode) before it is released.
- R6: In the default mode, clear_to_send rises in the same clock as each blank. It stays high through the blank and falls once floor(2*2**GS_BITS/3) grayscale periods of the following cycle have passed. For the bench settings that is 10 periods, or 40 clocks after the run starts.
- R7: A frame_done strobe drops clear_to_send on the next clock, unless a blank starts on that same clock.
- R8: Straight after reset, blank is high and the latch output, the grayscale clock and clear_to_send are low.
- R9: With ALT_MODE set, the blank stays high with no latch pulse until frame_done. clear_to_send is high only during that wait. After the strobe comes one latch pulse, then the release of blank and a full cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Global output enable; low forces the outputs dark |
| frame_done | input | 1 | One-clock strobe from the serializer: a full frame has been shifted |
| gsclk | output | 1 | Gated grayscale clock |
| blank | output | 1 | Blanking output, high ends the PWM cycle and darkens the drivers |
| xlat | output | 1 | Latch pulse for the shifted frame |
| clear_to_send | output | 1 | Window in which the serializer may begin a frame |

## Verification
The assertions assume that enable and frame_done are synchronous to clk and that frame_done is a single-clock strobe. They also assume BLANK_CLKS is at least 3, so that the latch pulse has a blanked clock on each side. The bench changes every input just after a falling clock edge and makes frame_done exactly one clock wide. It strobes frame_done only inside an open window or, in the second mode, during the wait. It drops enable in the middle of a run, so the forced-dark path is reached from a running grayscale clock and not only from idle.

// File: rtl/gs_seq_pkg.sv
package gs_seq_pkg;
    typedef enum logic [2:0] {
        ST_DARK,
        ST_RUN,
        ST_STOP,
        ST_WAIT,
        ST_BLANK
    } seq_state_e;
endpackage

// File: rtl/gs_clk_div.sv
module gs_clk_div #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic gsclk_o,
    output logic tick_o
);
    localparam int CW = (2 * HALF_DIV > 2) ? $clog2(2 * HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(2 * HALF_DIV - 1);
    localparam logic [CW-1:0] HI_AT = CW'(HALF_DIV);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          clk_out;
    } div_t;

    div_t q, d;

    always_comb begin
        d = q;
        tick_o = 1'b0;
        if (!run_i) begin
            d.cnt = '0;
            d.clk_out = 1'b0;
        end else begin
            tick_o = (q.cnt == LAST);
            d.cnt = tick_o ? '0 : q.cnt + 1'b1;
            d.clk_out = (d.cnt >= HI_AT);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign gsclk_o = q.clk_out;

    // R1: a completed period always leaves the clock low
    p_period_end_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !gsclk_o);

    // R1: a stopped divider never produces a high level
    p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !gsclk_o);
endmodule

// File: rtl/gs_pend_flag.sv
module gs_pend_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_done,
    input  logic consume_i,
    output logic pend_o
);
    logic pend_q, pend_d;

    always_comb begin
        pend_d = frame_done | (pend_q & ~consume_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;

    // R3: a finished frame is always remembered for the next blank
    p_pend_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> pend_o);
endmodule

// File: rtl/gs_cycle_fsm.sv
module gs_cycle_fsm
    import gs_seq_pkg::*;
#(
    parameter int GS_BITS    = 12,
    parameter int BLANK_CLKS = 8,
    parameter bit ALT_MODE   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic frame_done,
    input  logic tick_i,
    input  logic gsclk_i,
    input  logic pend_i,
    output logic run_o,
    output logic consume_o,
    output logic blank_o,
    output logic xlat_o,
    output logic cts_o
);
    localparam int CYC = 1 << GS_BITS;
    localparam int WIN = (2 * CYC) / 3;
    localparam int BW  = (BLANK_CLKS > 2) ? $clog2(BLANK_CLKS) : 1;
    localparam logic [GS_BITS-1:0] P_LAST = GS_BITS'(CYC - 1);
    localparam logic [GS_BITS-1:0] P_WIN  = GS_BITS'(WIN - 1);
    localparam logic [BW-1:0]      B_LAST = BW'(BLANK_CLKS - 1);

    typedef struct packed {
        seq_state_e         st;
        logic [BW-1:0]      bcnt;
        logic [GS_BITS-1:0] pcnt;
        logic               blank;
        logic               xlat;
        logic               cts;
    } fsm_t;

    fsm_t q, d;

    always_comb begin
        d = q;
        d.xlat = 1'b0;
        consume_o = 1'b0;
        if (frame_done) d.cts = 1'b0;
        case (q.st)
            ST_DARK: begin
                d.blank = 1'b1;
                d.cts = 1'b0;
                if (enable) begin
                    d.bcnt = '0;
                    d.cts = 1'b1;
                    d.st = ALT_MODE ? ST_WAIT : ST_BLANK;
                end
            end
            ST_RUN: begin
                d.blank = 1'b0;
                if (tick_i) begin
                    if (q.pcnt == P_WIN) d.cts = 1'b0;
                    if (q.pcnt == P_LAST) begin
                        d.st = ST_STOP;
                        d.pcnt = '0;
                    end else begin
                        d.pcnt = q.pcnt + 1'b1;
                    end
                end
            end
            ST_STOP: begin
                d.blank = 1'b1;
                d.bcnt = '0;
                d.cts = 1'b1;
                d.st = ALT_MODE ? ST_WAIT : ST_BLANK;
            end
            ST_WAIT: begin
                d.blank = 1'b1;
                if (pend_i) begin
                    d.st = ST_BLANK;
                    d.bcnt = '0;
                end
            end
            ST_BLANK: begin
                d.blank = 1'b1;
                if (q.bcnt == '0 && pend_i) begin
                    consume_o = 1'b1;
                    d.xlat = 1'b1;
                end
                if (q.bcnt == B_LAST) begin
                    d.st = ST_RUN;
                    d.blank = 1'b0;
                    d.pcnt = '0;
                end else begin
                    d.bcnt = q.bcnt + 1'b1;
                end
            end
            default: d.st = ST_DARK;
        endcase
        if (!enable) begin
            d.st = ST_DARK;
            d.blank = 1'b1;
            d.cts = 1'b0;
            d.xlat = 1'b0;
            d.pcnt = '0;
            consume_o = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st    <= ST_DARK;
            q.bcnt  <= '0;
            q.pcnt  <= '0;
            q.blank <= 1'b1;
            q.xlat  <= 1'b0;
            q.cts   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign run_o   = (q.st == ST_RUN) && enable;
    assign blank_o = q.blank;
    assign xlat_o  = q.xlat;
    assign cts_o   = q.cts;

    // R2: the grayscale clock was already low when a cycle-end blank rose
    p_stop_before_blank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.blank) && $past(enable) |-> !$past(gsclk_i));

    // R2: no grayscale clock activity while blanked
    p_gsclk_low_in_blank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.blank |-> !gsclk_i);

    // R3: latch pulse lies inside the blank with margin before it
    p_xlat_in_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q.xlat |-> q.blank && $past(q.blank));

    // R3: latch pulse is one clock wide and followed by a blanked clock
    p_xlat_tail_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q.xlat |=> q.blank && !q.xlat);

    // R4: disable forces dark outputs on the next clock
    p_dark_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> q.blank && !gsclk_i && !q.cts && !q.xlat);

    // R6: window never open past two thirds of the run
    p_cts_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.cts && q.st == ST_RUN |-> q.pcnt < GS_BITS'(WIN));

    // R7: a finished frame closes the window
    p_cts_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && q.st != ST_STOP && q.st != ST_DARK |=> !q.cts);
endmodule

// File: rtl/gs_cycle_seq.sv
module gs_cycle_seq #(
    parameter int HALF_DIV   = 4,
    parameter int GS_BITS    = 12,
    parameter int BLANK_CLKS = 8,
    parameter bit ALT_MODE   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic frame_done,
    output logic gsclk,
    output logic blank,
    output logic xlat,
    output logic clear_to_send
);
    logic run, tick, pend, consume;

    gs_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run),
        .gsclk_o (gsclk),
        .tick_o  (tick)
    );

    gs_pend_flag u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .consume_i  (consume),
        .pend_o     (pend)
    );

    gs_cycle_fsm #(
        .GS_BITS    (GS_BITS),
        .BLANK_CLKS (BLANK_CLKS),
        .ALT_MODE   (ALT_MODE)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .frame_done (frame_done),
        .tick_i     (tick),
        .gsclk_i    (gsclk),
        .pend_i     (pend),
        .run_o      (run),
        .consume_o  (consume),
        .blank_o    (blank),
        .xlat_o     (xlat),
        .cts_o      (clear_to_send)
    );
endmodule

// File: tb/test_gs_cycle_seq.sv
module test_gs_cycle_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_a = 1'b0, fd_a = 1'b0, en_b = 1'b0, fd_b = 1'b0;
    logic g_a, b_a, x_a, c_a, g_b, b_b, x_b, c_b;
    int nchk = 0, nerr = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gs_cycle_seq #(.HALF_DIV(2), .GS_BITS(4), .BLANK_CLKS(4), .ALT_MODE(1'b0)) i_gs_cycle_seq (
        .clk(clk), .rst_n(rst_n), .enable(en_a), .frame_done(fd_a),
        .gsclk(g_a), .blank(b_a), .xlat(x_a), .clear_to_send(c_a));

    gs_cycle_seq #(.HALF_DIV(2), .GS_BITS(4), .BLANK_CLKS(4), .ALT_MODE(1'b1)) i_gs_cycle_seq_alt (
        .clk(clk), .rst_n(rst_n), .enable(en_b), .frame_done(fd_b),
        .gsclk(g_b), .blank(b_b), .xlat(x_b), .clear_to_send(c_b));

    // bit 1: strobe a frame in the run, bit 0: expected latch pulses in the next blank
    localparam logic [1:0] VEC [6] = '{2'b00, 2'b11, 2'b11, 2'b00, 2'b11, 2'b00};

    task automatic check(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run_cycle(input bit frame, input int exp_x);
        int rises = 0, len = 0, cts_run = 0, bw = 0, cts_bl = 0, xl = 0, gl = 0;
        logic pg;
        while (b_a) @(negedge clk);
        pg = g_a;
        while (!b_a) begin
            len++;
            if (g_a && !pg) rises++;
            if (c_a) cts_run++;
            fd_a = (frame && len == 6);
            pg = g_a;
            @(negedge clk);
        end
        fd_a = 1'b0;
        check("R1 grayscale rises per cycle", rises, 16);
        check("R1 run length in clocks", len, 65);
        check("R2 clock low before blank", int'(pg), 0);
        check(frame ? "R7 window closed by frame" : "R6 window length in run", cts_run, frame ? 6 : 40);
        while (b_a) begin
            bw++;
            if (c_a) cts_bl++;
            if (x_a) xl++;
            if (g_a) gl++;
            @(negedge clk);
        end
        check("R2 blank width", bw, 4);
        check("R2 clock low in blank", gl, 0);
        check("R6 window open in blank", cts_bl, 4);
        check("R3 latch pulses", xl, exp_x);
    endtask

    initial begin
        int cnt, lo, hi, xl;
        repeat (3) @(negedge clk);
        check("R8 blank after reset", int'(b_a), 1);
        check("R8 xlat after reset", int'(x_a), 0);
        check("R8 gsclk after reset", int'(g_a), 0);
        check("R8 cts after reset", int'(c_a), 0);
        rst_n = 1'b1;
        lo = 0;
        repeat (10) begin @(negedge clk); if (!b_a || g_a) lo++; end
        check("R4 dark while disabled", lo, 0);

        en_a = 1'b1;
        cnt = 0;
        @(negedge clk);
        check("R6 window opens with blank", int'(c_a), 1);
        while (b_a && cnt < 50) begin cnt++; @(negedge clk); end
        check("R5 blank after enable", cnt, 4);

        for (int i = 0; i < 6; i++) run_cycle(VEC[i][1], int'(VEC[i][0]));

        while (b_a) @(negedge clk);
        repeat (20) @(negedge clk);
        en_a = 1'b0;
        @(negedge clk);
        check("R4 blank on disable", int'(b_a), 1);
        check("R4 gsclk on disable", int'(g_a), 0);
        check("R4 cts on disable", int'(c_a), 0);
        lo = 0;
        repeat (50) begin @(negedge clk); if (!b_a || g_a || c_a || x_a) lo++; end
        check("R4 held dark", lo, 0);
        en_a = 1'b1;
        cnt = 0;
        @(negedge clk);
        while (b_a && cnt < 50) begin cnt++; @(negedge clk); end
        check("R5 blank after re-enable", cnt, 4);
        run_cycle(1'b0, 0);

        // second mode
        en_b = 1'b1;
        lo = 0; xl = 0;
        repeat (30) begin @(negedge clk); if (!b_b) lo++; if (x_b) xl++; end
        check("R9 blank held waiting", lo, 0);
        check("R9 no latch before frame", xl, 0);
        check("R9 window open in wait", int'(c_b), 1);
        fd_b = 1'b1;
        @(negedge clk);
        fd_b = 1'b0;
        xl = 0; cnt = 0;
        while (b_b && cnt < 20) begin cnt++; if (x_b) xl++; @(negedge clk); end
        check("R9 latch after frame", xl, 1);
        check("R9 blank released", int'(b_b), 0);
        hi = 0; cnt = 0;
        begin
            logic pg = g_b;
            while (!b_b && cnt < 200) begin
                cnt++;
                if (g_b && !pg) hi++;
                if (c_b) lo++;
                pg = g_b;
                @(negedge clk);
            end
        end
        check("R9 full cycle rises", hi, 16);
        check("R9 window shut during run", lo, 0);
        lo = 0; xl = 0;
        repeat (20) begin @(negedge clk); if (!b_b) lo++; if (x_b) xl++; end
        check("R9 second wait blanked", lo, 0);
        check("R9 second wait no latch", xl, 0);
        check("R9 second wait window", int'(c_b), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end
endmodule